// File: doc/BRIEF.md
# SPI Clock and Chip-Select Timing Generator

This block generates the serial clock and the active-low chip select of an SPI master. A transfer engine asks for a packet with a start request. The block then frames the packet: it lowers chip select, waits a programmable setup time, and runs one clock period per bit. At the end of each bit it raises a bit-end strobe. The engine answers at that point with a last-bit flag, which decides whether another bit follows. After the final bit the block holds chip select low for a programmable hold time. It then keeps chip select high for a programmable idle gap before it can start the next packet.

Five 8-bit counts set the timing: clock high, clock low, chip-select setup, chip-select hold and inter-packet idle. Each count stores the wanted number of source-clock cycles minus one. Clock polarity sets the resting level of the serial clock. Clock phase chooses whether data is captured on the first or the second edge of each bit. The block emits one-cycle shift and sample strobes aligned to those edges, so a separate shift register can drive and capture data. When the engine wants a rate of f_req from a source clock f_src, it programs the counts as follows:
- If f_req is at least f_src/2, it uses a divisor of 1 and single-cycle phases.
- Otherwise the divisor is ceil(f_src/f_req), each clock phase lasts (div+1)/2 cycles, and the chip-select times are twice one phase.

Top module: `spiClkCsGen`

## Requirements
- R1: `timingCfg` packs four counts: clock-high time in bits 7:0, clock-low time in bits 15:8, chip-select hold in bits 23:16 and chip-select setup in bits 31:24. A value v gives v+1 source cycles. The serial clock stays high for high+1 cycles and low for low+1 cycles of every bit.
- R2: The first serial-clock edge of a packet comes exactly setup+1 cycles after chip select falls. The serial clock never changes while chip select is high, except while the block is idle.
- R3: Chip select rises exactly hold+1 cycles after the last trailing edge of a packet.
- R4: Between packets, chip select stays high for idle+1 cycles, where idle is `idleCfg` with the same minus-one encoding. `busy` stays high until that gap ends. A start request held at the end of the gap begins the next packet with no extra cycle.
- R5: With `cpol`=0 the serial clock rests low. With `cpol`=1 it rests high. Each bit starts with a leading phase at the non-resting level, followed by a trailing phase at the resting level.
- R6: With `cpha`=0, `sampleStb` pulses in the first cycle of the leading phase and `shiftStb` in the first cycle of the trailing phase. With `cpha`=1 the two are swapped. Each strobe lasts one cycle.
- R7: `bitEnd` pulses in the last cycle of each trailing phase. `lastBit` is sampled in that cycle: 1 ends the packet, 0 starts another bit.
- R8: All counts, `cpol` and `cpha` are captured when a packet is accepted. Changes made during the packet have no effect until the next packet.
- R9: A synchronous reset drives the serial clock to the `cpol` level, raises chip select, clears `busy` and all strobes. While idle, the serial clock follows `cpol`.
- R10: A start request during setup, bit or hold phases is ignored. The running packet keeps its timing, and no new packet follows it unless a request is present at the end of the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Request to start a packet |
| lastBit | input | 1 | Current bit is the packet's last, sampled with bitEnd |
| timingCfg | input | 32 | Clock high, clock low, hold and setup counts |
| idleCfg | input | 8 | Inter-packet idle count |
| cpol | input | 1 | Serial-clock resting level |
| cpha | input | 1 | Capture on second edge when 1 |
| sclk | output | 1 | Serial clock |
| csN | output | 1 | Chip select, active low |
| shiftStb | output | 1 | One-cycle strobe: drive next data bit |
| sampleStb | output | 1 | One-cycle strobe: capture data bit |
| bitEnd | output | 1 | Last cycle of a bit period |
| busy | output | 1 | Packet or idle gap in progress |

## Verification
The assertions check, on every cycle, the rules that hold at all times:
- the serial clock moves only inside a chip-select frame;
- chip select falls with the clock at its resting level;
- each strobe lines up with a clock transition;
- no packet restarts from the middle of another;
- an idle block stays quiet.

Exact phase lengths for each count value can only be shown by the bench's packets. So can the link between strobe placement and polarity or phase, the back-to-back gap length and the capture of configuration at packet start. The bench compares every output cycle by cycle against an expected timeline built from the counts. Its packets cover all four modes, single-cycle and maximum counts, chained packets, changes to configuration during a packet and a reset during a packet.

// File: rtl/spiTimPkg.sv
package spiTimPkg;

  // Phases of one packet frame, in the order they run
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_LEAD  = 3'd2,
    PH_TRAIL = 3'd3,
    PH_HOLD  = 3'd4,
    PH_GAP   = 3'd5
  } phase_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic   latchCfg;  // capture configuration this cycle
    logic   enter;     // a new phase begins at the next edge
    phase_e nextPh;    // phase being entered
    phase_e curPh;     // phase currently running
  } seqCtl_t;

endpackage

// File: rtl/spiTimSequencer.sv
module spiTimSequencer
  import spiTimPkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    startReq,
  input  logic    lastBit,
  input  logic    cntZero,
  output seqCtl_t ctl,
  output logic    bitEnd,
  output logic    busy
);

  phase_e curPh;
  phase_e nextPh;
  logic   latch;

  always_comb begin
    nextPh = curPh;
    latch  = 1'b0;
    unique case (curPh)
      PH_IDLE: begin
        if (startReq) begin
          nextPh = PH_SETUP;
          latch  = 1'b1;
        end
      end
      PH_SETUP: if (cntZero) nextPh = PH_LEAD;
      PH_LEAD:  if (cntZero) nextPh = PH_TRAIL;
      PH_TRAIL: if (cntZero) nextPh = lastBit ? PH_HOLD : PH_LEAD;
      PH_HOLD:  if (cntZero) nextPh = PH_GAP;
      PH_GAP: begin
        if (cntZero) begin
          if (startReq) begin
            nextPh = PH_SETUP;
            latch  = 1'b1;
          end else begin
            nextPh = PH_IDLE;
          end
        end
      end
      default: nextPh = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) curPh <= PH_IDLE;
    else     curPh <= nextPh;
  end

  always_comb begin
    ctl.latchCfg = latch;
    ctl.enter    = (nextPh != curPh);
    ctl.nextPh   = nextPh;
    ctl.curPh    = curPh;
  end

  assign bitEnd = (curPh == PH_TRAIL) && cntZero;
  assign busy   = (curPh != PH_IDLE);

  // R10: a running frame never jumps back to setup
  a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
    ($past(curPh) == PH_LEAD || $past(curPh) == PH_TRAIL || $past(curPh) == PH_HOLD)
      |-> curPh != PH_SETUP);

  // R7: after a bit ends, either another bit or the hold phase follows
  a_r7_bit_follow: assert property (@(posedge clk) disable iff (rst)
    bitEnd |=> (curPh == PH_LEAD || curPh == PH_HOLD));

endmodule

// File: rtl/spiTimDatapath.sv
module spiTimDatapath
  import spiTimPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [4*CNT_W-1:0] timingCfg,
  input  logic [CNT_W-1:0]   idleCfg,
  input  logic               cpol,
  input  logic               cpha,
  input  seqCtl_t            ctl,
  output logic               cntZero,
  output logic               sclk,
  output logic               csN,
  output logic               shiftStb,
  output logic               sampleStb
);

  localparam int NUM_F   = 5;
  localparam int NUM_CFG = 4;
  localparam int F_HIGH  = 0;
  localparam int F_LOW   = 1;
  localparam int F_HOLD  = 2;
  localparam int F_SETUP = 3;
  localparam int F_IDLE  = 4;

  logic [CNT_W-1:0] liveF [NUM_F];
  logic [CNT_W-1:0] heldF [NUM_F];
  logic [CNT_W-1:0] useF  [NUM_F];
  logic             cpolL, cphaL, useCpol;
  logic [CNT_W-1:0] leadLen, trailLen, loadVal, cnt;
  logic             first;

  // Split the packed word into counts
  always_comb begin
    for (int i = 0; i < NUM_CFG; i++) liveF[i] = timingCfg[i*CNT_W +: CNT_W];
    liveF[F_IDLE] = idleCfg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_F; i++) heldF[i] <= '0;
      cpolL <= cpol;
      cphaL <= 1'b0;
    end else if (ctl.latchCfg) begin
      for (int i = 0; i < NUM_F; i++) heldF[i] <= liveF[i];
      cpolL <= cpol;
      cphaL <= cpha;
    end
  end

  // The accepting cycle uses the live values directly
  always_comb begin
    for (int i = 0; i < NUM_F; i++) useF[i] = ctl.latchCfg ? liveF[i] : heldF[i];
    useCpol = ctl.latchCfg ? cpol : cpolL;
  end

  // Leading phase sits at the non-resting level
  assign leadLen  = useCpol ? useF[F_LOW]  : useF[F_HIGH];
  assign trailLen = useCpol ? useF[F_HIGH] : useF[F_LOW];

  always_comb begin
    unique case (ctl.nextPh)
      PH_SETUP: loadVal = useF[F_SETUP];
      PH_LEAD:  loadVal = leadLen;
      PH_TRAIL: loadVal = trailLen;
      PH_HOLD:  loadVal = useF[F_HOLD];
      PH_GAP:   loadVal = useF[F_IDLE];
      default:  loadVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (ctl.enter)     cnt <= loadVal;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk  <= cpol;
      csN   <= 1'b1;
      first <= 1'b0;
    end else begin
      first <= ctl.enter;
      if (ctl.enter) begin
        sclk <= (ctl.nextPh == PH_LEAD) ? ~useCpol : useCpol;
        csN  <= (ctl.nextPh == PH_IDLE) || (ctl.nextPh == PH_GAP);
      end else if (ctl.curPh == PH_IDLE) begin
        sclk <= cpol;
      end
    end
  end

  logic leadEdge, trailEdge;
  assign leadEdge  = first && (ctl.curPh == PH_LEAD);
  assign trailEdge = first && (ctl.curPh == PH_TRAIL);
  assign sampleStb = cphaL ? trailEdge : leadEdge;
  assign shiftStb  = cphaL ? leadEdge  : trailEdge;

  // R2: clock moves only inside a chip-select frame
  a_r2_clk_in_frame: assert property (@(posedge clk) disable iff (rst)
    (ctl.curPh != PH_IDLE && sclk != $past(sclk)) |-> !csN);

  // R5: chip select falls with the clock at its resting level
  a_r5_cs_fall_rest: assert property (@(posedge clk) disable iff (rst)
    $fell(csN) |-> sclk == cpolL);

  // R6: strobes coincide with a clock transition
  a_r6_sample_on_edge: assert property (@(posedge clk) disable iff (rst)
    sampleStb |-> sclk != $past(sclk));
  a_r6_shift_on_edge: assert property (@(posedge clk) disable iff (rst)
    shiftStb |-> sclk != $past(sclk));

endmodule

// File: rtl/spiClkCsGen.sv
module spiClkCsGen
  import spiTimPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               startReq,
  input  logic               lastBit,
  input  logic [4*CNT_W-1:0] timingCfg,
  input  logic [CNT_W-1:0]   idleCfg,
  input  logic               cpol,
  input  logic               cpha,
  output logic               sclk,
  output logic               csN,
  output logic               shiftStb,
  output logic               sampleStb,
  output logic               bitEnd,
  output logic               busy
);

  seqCtl_t ctl;
  logic    cntZero;

  spiTimSequencer uSeq (
    .clk      (clk),
    .rst      (rst),
    .startReq (startReq),
    .lastBit  (lastBit),
    .cntZero  (cntZero),
    .ctl      (ctl),
    .bitEnd   (bitEnd),
    .busy     (busy)
  );

  spiTimDatapath #(.CNT_W(CNT_W)) uDp (
    .clk       (clk),
    .rst       (rst),
    .timingCfg (timingCfg),
    .idleCfg   (idleCfg),
    .cpol      (cpol),
    .cpha      (cpha),
    .ctl       (ctl),
    .cntZero   (cntZero),
    .sclk      (sclk),
    .csN       (csN),
    .shiftStb  (shiftStb),
    .sampleStb (sampleStb)
  );

  // R9: an idle block holds chip select high and emits no strobes
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (csN && !shiftStb && !sampleStb));

endmodule

// File: tb/sim_spiClkCsGen.sv
module sim_spiClkCsGen;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst;
  logic        startReq, lastBit;
  logic [31:0] timingCfg;
  logic [7:0]  idleCfg;
  logic        cpol, cpha;
  logic        sclk, csN, shiftStb, sampleStb, bitEnd, busy;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // expected-timeline parameters of the packet under observation
  int   eS, eA, eB, eH, eI, eN;
  logic eCpol, eCpha;
  // configuration of a chained follow-up packet
  logic [31:0] nT;
  logic [7:0]  nI;
  logic        nP, nH;

  string sigName [6] = '{"R7 bitEnd", "R6 shift", "R6 sample",
                         "R1 R5 sclk", "R2 R3 csN", "R4 busy"};

  always #(CLK_PERIOD/2) clk = ~clk;

  spiClkCsGen u0 (
    .clk(clk), .rst(rst), .startReq(startReq), .lastBit(lastBit),
    .timingCfg(timingCfg), .idleCfg(idleCfg), .cpol(cpol), .cpha(cpha),
    .sclk(sclk), .csN(csN), .shiftStb(shiftStb), .sampleStb(sampleStb),
    .bitEnd(bitEnd), .busy(busy)
  );

  task automatic check(bit ok, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  function automatic void setExp(logic [31:0] t, logic [7:0] i, logic p, logic h, int n);
    int hi, lo;
    hi = int'(t[7:0]) + 1;
    lo = int'(t[15:8]) + 1;
    eS = int'(t[31:24]) + 1;
    eH = int'(t[23:16]) + 1;
    eA = p ? lo : hi;
    eB = p ? hi : lo;
    eI = int'(i) + 1;
    eN = n;
    eCpol = p;
    eCpha = h;
  endfunction

  function automatic int frameLen();
    return eS + eN * (eA + eB) + eH + eI;
  endfunction

  // {busy, csN, sclk, sample, shift, bitEnd} for cycle k after acceptance
  function automatic logic [5:0] expAt(int k);
    int act, csEnd, tot, j;
    logic b, c, s, sm, sh, be, lead, trail;
    act   = eS + eN * (eA + eB);
    csEnd = act + eH;
    tot   = csEnd + eI;
    b  = (k < tot);
    c  = !(k < csEnd);
    s  = eCpol;
    sm = 1'b0; sh = 1'b0; be = 1'b0;
    if (k >= eS && k < act) begin
      j     = (k - eS) % (eA + eB);
      s     = (j < eA) ? ~eCpol : eCpol;
      lead  = (j == 0);
      trail = (j == eA);
      be    = (j == eA + eB - 1);
      sm    = eCpha ? trail : lead;
      sh    = eCpha ? lead : trail;
    end
    return {b, c, s, sm, sh, be};
  endfunction

  // Follows the packet from its accepting edge, cycle by cycle
  task automatic observe(bit chain);
    int tot, bitsDone;
    int firstK [6];
    int errs   [6];
    logic [5:0] got, want, fAct, fExp;
    tot = frameLen();
    bitsDone = 0;
    fAct = '0; fExp = '0;
    for (int i = 0; i < 6; i++) begin errs[i] = 0; firstK[i] = 0; end
    @(posedge clk);
    for (int k = 0; k < tot; k++) begin
      @(negedge clk);
      if (k == 0) startReq = 1'b0;
      got  = {busy, csN, sclk, sampleStb, shiftStb, bitEnd};
      want = expAt(k);
      for (int i = 0; i < 6; i++) begin
        if (got[i] !== want[i]) begin
          if (errs[i] == 0) begin
            firstK[i] = k; fAct[i] = got[i]; fExp[i] = want[i];
          end
          errs[i]++;
        end
      end
      lastBit = (bitsDone == eN - 1);
      if (bitEnd) bitsDone++;
      if (k == 1) begin  // R8: disturb configuration mid-packet
        timingCfg = $urandom;
        idleCfg   = 8'($urandom);
        cpol      = ~cpol;
        cpha      = ~cpha;
      end
      if (k == 2) startReq = 1'b1;  // R10: request while busy
      if (k == 3) startReq = 1'b0;
      if (chain && k == tot - 1) begin
        timingCfg = nT; idleCfg = nI; cpol = nP; cpha = nH;
        startReq  = 1'b1;
      end
    end
    for (int i = 0; i < 6; i++)
      check(errs[i] == 0, $sformatf("%s first mismatch at cycle %0d", sigName[i], firstK[i]),
            int'(fAct[i]), int'(fExp[i]));
    check(errs[0] + errs[1] + errs[2] + errs[3] + errs[4] + errs[5] == 0,
          "R8 timing unaffected by mid-packet config change", 0, 0);
    if (!chain) begin
      @(negedge clk);
      check(!busy && csN, "R10 no packet from ignored request", int'({busy, csN}), 1);
    end
  endtask

  task automatic runOne(logic [31:0] t, logic [7:0] i, logic p, logic h, int n);
    setExp(t, i, p, h, n);
    timingCfg = t; idleCfg = i; cpol = p; cpha = h;
    startReq  = 1'b1;
    observe(1'b0);
  endtask

  task automatic runChain(logic [31:0] t, logic [7:0] i, logic p, logic h, int n, int n2);
    setExp(t, i, p, h, n);
    timingCfg = t; idleCfg = i; cpol = p; cpha = h;
    startReq  = 1'b1;
    observe(1'b1);
    setExp(nT, nI, nP, nH, n2);
    observe(1'b0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=%0d exp=%0d", WATCHDOG, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seedTap;
    seedTap = $urandom(32'd5813);
    rst = 1'b1; startReq = 1'b0; lastBit = 1'b0;
    timingCfg = 32'h0101_0202; idleCfg = 8'd1; cpol = 1'b1; cpha = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(sclk == cpol && csN && !busy && !sampleStb && !shiftStb && !bitEnd,
          "R9 reset state", int'({sclk, csN, busy, sampleStb, shiftStb, bitEnd}), 6'b110000);
    rst = 1'b0;
    @(negedge clk);

    // R5 R6: all four polarity / phase modes
    for (int m = 0; m < 4; m++) runOne(32'h0203_0102, 8'd2, m[1], m[0], 3);

    // R9: idle clock follows cpol
    cpol = 1'b0;
    repeat (2) @(negedge clk);
    check(sclk == 1'b0, "R9 idle sclk tracks cpol=0", int'(sclk), 0);
    cpol = 1'b1;
    repeat (2) @(negedge clk);
    check(sclk == 1'b1, "R9 idle sclk tracks cpol=1", int'(sclk), 1);

    // R1: single-cycle counts, one- and two-bit packets
    runOne(32'h0000_0000, 8'd0, 1'b0, 1'b0, 2);
    runOne(32'h0000_0000, 8'd0, 1'b1, 1'b1, 1);
    // R2 R3 R4: maximum setup, hold and idle counts
    runOne(32'hFFFF_0102, 8'hFF, 1'b1, 1'b1, 1);
    // R1: asymmetric high/low
    runOne(32'h0100_0500, 8'd3, 1'b0, 1'b1, 4);

    // R4: back-to-back packets with the request held at the gap end
    nT = 32'h0002_0101; nI = 8'd4; nP = 1'b1; nH = 1'b0;
    runChain(32'h0300_0201, 8'd2, 1'b0, 1'b0, 2, 3);

    // mixed random packets, some chained
    for (int r = 0; r < 24; r++) begin
      logic [31:0] t;
      logic [7:0]  i;
      logic        p, h;
      int          n;
      t = $urandom & 32'h0707_0707;
      i = 8'($urandom % 8);
      p = 1'($urandom);
      h = 1'($urandom);
      n = 1 + int'($urandom % 9);
      if (r % 3 == 2) begin
        nT = $urandom & 32'h0505_0303;
        nI = 8'($urandom % 6);
        nP = 1'($urandom);
        nH = 1'($urandom);
        runChain(t, i, p, h, n, 1 + int'($urandom % 5));
      end else begin
        runOne(t, i, p, h, n);
      end
    end

    // R9: synchronous reset in the middle of a packet
    timingCfg = 32'h0202_0303; idleCfg = 8'd2; cpol = 1'b0; cpha = 1'b1;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (6) @(negedge clk);
    check(!csN && busy, "R9 packet running before reset", int'({csN, busy}), 1);
    cpol = 1'b1;
    rst  = 1'b1;
    @(negedge clk);
    check(sclk == 1'b1 && csN && !busy && !sampleStb && !shiftStb,
          "R9 mid-packet reset returns to idle", int'({sclk, csN, busy}), 3'b110);
    rst = 1'b0;
    @(negedge clk);
    runOne(32'h0101_0101, 8'd1, 1'b1, 1'b0, 2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule